// File: doc/BRIEF.md
# SRAM Write Posting Buffer

This block sits between a CPU-side load/store port and a single-port synchronous SRAM. Every accepted write is captured in a one-entry posting register and completes in one cycle. The previously posted write goes into the array only when the next write arrives. Commit and capture happen in the same clock edge, so back-to-back stores never stall.

Loads that address the word held in the posting register return the array word with the posted byte lanes substituted. A reset empties the posting register without committing it, so the array keeps its older contents. Software that needs the data to survive a reset issues the same store twice, or follows the store with a dummy store, before the reset or before a low-power entry. Byte, halfword and word accesses are decoded into byte enables on a 32-bit bus. Misaligned accesses and the reserved size code are rejected.

Top module: `sram_wbuf`

## Requirements
- R1: `size_i` encodes 0 = byte, 1 = halfword, 2 = word and 3 = reserved. The lane offset is `addr_i[1:0]`. Write data is right-justified in `wdata_i`, and only the addressed lanes are written.
- R2: An accepted write is held in the posting register and is not written into the array while no further write is accepted.
- R3: A valid read raises `rvalid_o` in the cycle after the request. `rdata_o` then holds the addressed byte, halfword or word, right-justified and zero-extended.
- R4: A halfword at an odd address, a word whose address is not a multiple of 4, or size code 3 raises `err_o` in the next cycle with `rvalid_o` low. Such an access changes neither the posting register nor the array.
- R5: Each accepted write commits the previously posted write into the array in the same cycle that it is captured, so a write can be accepted in every cycle.
- R6: A read of the word held in the posting register returns the array word with the posted byte lanes substituted.
- R7: Reset discards the posted write. A read after reset returns the array contents that were present before the discarded write.
- R8: The same write issued twice in a row is present in the array after a reset.
- R9: A dummy write to any address, issued after a write, commits that write so that it survives a following reset.
- R10: Reads never commit the posted write and never change the posting register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size code |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Right-justified write data |
| rdata_o | output | DATA_W | Right-justified read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| err_o | output | 1 | Misaligned or reserved-size access, one cycle after the request |

## Verification
The assertions assume that the CPU port holds no two outstanding requests and never raises `req_i` with an undriven size or address. They also take for granted that the posting register is the only path into the array. The directed stimulus presents one request per cycle, changed away from the rising edge, with `req_i` low between scenarios. Array words are read back only after the bench has written and committed them, so no check depends on uninitialised memory.

// File: rtl/sram_wbuf_pkg.sv
package sram_wbuf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/sram_wbuf_lane_dec.sv
module sram_wbuf_lane_dec #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(NB)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NB-1:0]     be_o,
  output logic [DATA_W-1:0] lane_data_o,
  output logic              misaligned_o
);
  int unsigned nbytes;
  int unsigned off;

  always_comb begin
    nbytes       = 32'd1 << size_i;
    off          = 32'(off_i);
    misaligned_o = (size_i == sram_wbuf_pkg::SZ_RSVD) || (nbytes > NB) ||
                   ((off % nbytes) != 0);
    for (int unsigned l = 0; l < NB; l++) begin
      be_o[l] = !misaligned_o && (l >= off) && (l < off + nbytes);
    end
    lane_data_o = wdata_i << (8 * off);
  end
endmodule

// File: rtl/sram_wbuf_array.sv
module sram_wbuf_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned WORDS = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [NB-1:0]     be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem[idx_i] <= wdata_i[8*l +: 8];
      if (re_i)            rd_q       <= mem[idx_i];
    end

    assign rdata_o[8*l +: 8] = rd_q;
  end
endmodule

// File: rtl/sram_wbuf_fwd.sv
module sram_wbuf_fwd #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] arr_word_i,
  input  logic              hit_i,
  input  logic [NB-1:0]     buf_be_i,
  input  logic [DATA_W-1:0] buf_word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] shifted;
  int unsigned       nbytes;

  for (genvar l = 0; l < NB; l++) begin : g_merge
    assign merged[8*l +: 8] = (hit_i && buf_be_i[l]) ? buf_word_i[8*l +: 8]
                                                      : arr_word_i[8*l +: 8];
  end

  always_comb begin
    nbytes  = 32'd1 << size_i;
    shifted = merged >> (8 * 32'(off_i));
    for (int unsigned l = 0; l < NB; l++) begin
      rdata_o[8*l +: 8] = (l < nbytes) ? shifted[8*l +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_wbuf.sv
module sram_wbuf #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);
  localparam int unsigned NB    = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(NB);
  localparam int unsigned IDX_W = ADDR_W - OFF_W;

  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic [NB-1:0]     be;
  logic [DATA_W-1:0] lane_data;
  logic              mis;
  logic              wr_ok, rd_ok;

  // posting register
  logic              buf_valid_q;
  logic [IDX_W-1:0]  buf_idx_q;
  logic [NB-1:0]     buf_be_q;
  logic [DATA_W-1:0] buf_data_q;

  // read snapshot
  logic              hit_q;
  logic [NB-1:0]     fwd_be_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [OFF_W-1:0]  rd_off_q;
  logic [1:0]        rd_size_q;
  logic              rvalid_q, err_q;

  logic              mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] arr_word;

  assign idx = addr_i[ADDR_W-1:OFF_W];
  assign off = addr_i[OFF_W-1:0];

  sram_wbuf_lane_dec #(.DATA_W(DATA_W)) u_dec (
    .size_i      (size_i),
    .off_i       (off),
    .wdata_i     (wdata_i),
    .be_o        (be),
    .lane_data_o (lane_data),
    .misaligned_o(mis)
  );

  assign wr_ok   = req_i && we_i && !mis;
  assign rd_ok   = req_i && !we_i && !mis;
  assign mem_we  = wr_ok && buf_valid_q;
  assign mem_idx = wr_ok ? buf_idx_q : idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_valid_q <= 1'b0;
      buf_idx_q   <= '0;
      buf_be_q    <= '0;
      buf_data_q  <= '0;
    end else if (wr_ok) begin
      buf_valid_q <= 1'b1;
      buf_idx_q   <= idx;
      buf_be_q    <= be;
      buf_data_q  <= lane_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q      <= 1'b0;
      fwd_be_q   <= '0;
      fwd_data_q <= '0;
      rd_off_q   <= '0;
      rd_size_q  <= '0;
      rvalid_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      err_q    <= req_i && mis;
      if (rd_ok) begin
        hit_q      <= buf_valid_q && (buf_idx_q == idx);
        fwd_be_q   <= buf_be_q;
        fwd_data_q <= buf_data_q;
        rd_off_q   <= off;
        rd_size_q  <= size_i;
      end
    end
  end

  sram_wbuf_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .re_i   (rd_ok),
    .idx_i  (mem_idx),
    .be_i   (buf_be_q),
    .wdata_i(buf_data_q),
    .rdata_o(arr_word)
  );

  sram_wbuf_fwd #(.DATA_W(DATA_W)) u_fwd (
    .arr_word_i(arr_word),
    .hit_i     (hit_q),
    .buf_be_i  (fwd_be_q),
    .buf_word_i(fwd_data_q),
    .off_i     (rd_off_q),
    .size_i    (rd_size_q),
    .rdata_o   (rdata_o)
  );

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/sram_wbuf_sva.sv
module sram_wbuf_sva #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rvalid_o,
  input logic              err_o,
  input logic              mem_we_i,
  input logic              buf_valid_i,
  input logic [DATA_W-1:0] buf_data_i
);
  logic bad;
  assign bad = (size_i == 2'd3) || (size_i == 2'd2 && addr_i[1:0] != 2'd0) ||
               (size_i == 2'd1 && addr_i[0]);

  a_r3_read_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !bad) |=> (rvalid_o && !err_o));

  a_r4_bad_access_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bad) |=> (err_o && !rvalid_o));

  a_r5_commit_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (req_i && we_i && !bad));

  a_r2_write_posted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !bad) |=> buf_valid_i);

  a_r10_read_keeps_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(buf_data_i));

  a_r4_outputs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rvalid_o, err_o}));
endmodule

bind sram_wbuf sram_wbuf_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .size_i     (size_i),
  .addr_i     (addr_i),
  .rvalid_o   (rvalid_o),
  .err_o      (err_o),
  .mem_we_i   (mem_we),
  .buf_valid_i(buf_valid_q),
  .buf_data_i (buf_data_q)
);

// File: tb/sram_wbuf_test.sv
module sram_wbuf_test;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [1:0]        size_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              rvalid_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sram_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    req_i  = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one request, returns at the negedge after the capturing edge
  task automatic access(logic w, logic [1:0] sz, logic [ADDR_W-1:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = w; size_i = sz; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] sz, logic [ADDR_W-1:0] a, logic [31:0] d);
    access(1'b1, sz, a, d);
  endtask

  task automatic rd_chk(string req, logic [1:0] sz, logic [ADDR_W-1:0] a, logic [31:0] exp);
    access(1'b0, sz, a, '0);
    check({req, " rvalid"}, {31'd0, rvalid_o}, 32'd1);
    check(req, rdata_o, exp);
  endtask

  task automatic t_reset_state();
    check("R3 reset rvalid", {31'd0, rvalid_o}, 32'd0);
    check("R4 reset err", {31'd0, err_o}, 32'd0);
  endtask

  task automatic t_sizes();
    wr(2'd2, 10'h010, 32'hA5A5_1234);
    wr(2'd0, 10'h021, 32'h0000_007E);
    wr(2'd1, 10'h032, 32'h0000_BEEF);
    wr(2'd2, 10'h03C, 32'h0);
    rd_chk("R1 word", 2'd2, 10'h010, 32'hA5A5_1234);
    rd_chk("R1 byte lane1", 2'd0, 10'h021, 32'h7E);
    rd_chk("R1 half upper", 2'd1, 10'h032, 32'hBEEF);
    rd_chk("R3 byte lane2", 2'd0, 10'h012, 32'hA5);
    rd_chk("R3 half lower", 2'd1, 10'h010, 32'h1234);
  endtask

  task automatic t_forward();
    wr(2'd2, 10'h040, 32'h1122_3344);
    wr(2'd2, 10'h044, 32'h0);
    wr(2'd0, 10'h041, 32'hAA);
    rd_chk("R6 merged word", 2'd2, 10'h040, 32'h1122_AA44);
    rd_chk("R6 posted byte", 2'd0, 10'h041, 32'hAA);
    rd_chk("R6 array half", 2'd1, 10'h042, 32'h1122);
  endtask

  task automatic t_back_to_back();
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      req_i = 1'b1; we_i = 1'b1; size_i = 2'd2;
      addr_i = ADDR_W'(10'h050 + 4 * i); wdata_i = 32'hB000_0000 + i;
      @(negedge clk_i);
    end
    req_i = 1'b0; we_i = 1'b0;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      rd_chk("R5 back-to-back commit", 2'd2, ADDR_W'(10'h050 + 4 * i), 32'hB000_0000 + i);
    end
  endtask

  task automatic t_errors();
    wr(2'd2, 10'h060, 32'hCAFE_F00D);
    access(1'b1, 2'd1, 10'h061, 32'hFFFF);
    check("R4 odd half err", {31'd0, err_o}, 32'd1);
    check("R4 odd half no rvalid", {31'd0, rvalid_o}, 32'd0);
    access(1'b1, 2'd2, 10'h062, 32'hFFFF_FFFF);
    check("R4 misaligned word err", {31'd0, err_o}, 32'd1);
    access(1'b0, 2'd3, 10'h060, 32'h0);
    check("R4 reserved size err", {31'd0, err_o}, 32'd1);
    check("R4 reserved size no rvalid", {31'd0, rvalid_o}, 32'd0);
    rd_chk("R4 buffer untouched", 2'd2, 10'h060, 32'hCAFE_F00D);
  endtask

  task automatic t_discard();
    wr(2'd2, 10'h070, 32'h1111_1111);
    wr(2'd2, 10'h074, 32'h0);
    wr(2'd2, 10'h070, 32'h2222_2222);
    rd_chk("R2 posted visible", 2'd2, 10'h070, 32'h2222_2222);
    do_reset();
    rd_chk("R7 discarded on reset", 2'd2, 10'h070, 32'h1111_1111);
  endtask

  task automatic t_double();
    wr(2'd2, 10'h070, 32'h3333_3333);
    wr(2'd2, 10'h070, 32'h3333_3333);
    do_reset();
    rd_chk("R8 double write kept", 2'd2, 10'h070, 32'h3333_3333);
  endtask

  task automatic t_dummy();
    wr(2'd2, 10'h070, 32'h4444_4444);
    wr(2'd0, 10'h07C, 32'h0);
    do_reset();
    rd_chk("R9 dummy write commit", 2'd2, 10'h070, 32'h4444_4444);
  endtask

  task automatic t_read_no_commit();
    wr(2'd2, 10'h070, 32'h5555_5555);
    rd_chk("R10 read hit", 2'd2, 10'h070, 32'h5555_5555);
    rd_chk("R10 other read", 2'd2, 10'h074, 32'h0);
    do_reset();
    rd_chk("R10 reads did not commit", 2'd2, 10'h070, 32'h4444_4444);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_sizes();
    t_forward();
    t_back_to_back();
    t_errors();
    t_discard();
    t_double();
    t_dummy();
    t_read_no_commit();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule